// File: doc/BRIEF.md
# Double-Buffered Serial Receive Stage

This block sits behind the bit sampler of a serial receiver and collects characters. Each sampled bit arrives on a one-cycle valid strobe. Bits arrive least significant first and are placed in a first-stage shift register. When the last bit of a character is sampled, the character moves into a holding register that the CPU reads, and a one-cycle receive interrupt pulse is raised. Because of the two stages, the next character can shift in while the CPU has not yet read the current one.

Four frame formats are selected by `mode_sel`:
- 0: seven data bits.
- 1: eight data bits.
- 2: eight data bits followed by a parity bit.
- 3: nine data bits.

In formats 2 and 3 the last bit received is kept as a separate extra bit. In format 3 an optional address-wake filter drops every character whose extra bit is 0.

If a character completes while the holding register still holds unread data, an overrun occurs. The new character is thrown away, the held character and its extra bit are kept, and a sticky overrun flag is set. Software clears this flag with a separate strobe.

Top module: `rxhold_stage`

## Requirements
- R1: After reset, `hold_data` is 0, `hold_extra` is 0, `rx_irq` is 0 and `ovr_flag` is 0.
- R2: With `mode_sel`=0 a character is 7 sampled bits, first bit into `hold_data[0]`; `hold_data[7]` and `hold_extra` read 0.
- R3: With `mode_sel`=1 a character is 8 sampled bits, first bit into `hold_data[0]`; `hold_extra` reads 0.
- R4: With `mode_sel`=2 a character is 9 sampled bits: the first 8 go to `hold_data[7:0]` and the ninth (parity) goes to `hold_extra`.
- R5: With `mode_sel`=3 a character is 9 sampled bits: the first 8 go to `hold_data[7:0]` and the ninth (data MSB) goes to `hold_extra`.
- R6: The holding register and `rx_irq` are updated by the same clock edge that samples the final bit. `rx_irq` is high for exactly one cycle.
- R7: A holding register that has been loaded counts as full until `rd_stb` is sampled. A read sampled on the same edge as a completing character counts as happening first, so the character loads and no overrun occurs.
- R8: A character that completes while the holding register is full is discarded. In that case `hold_data` and `hold_extra` keep their values, `rx_irq` stays 0, and `ovr_flag` becomes 1.
- R9: `ovr_flag` stays 1 until `ovr_clr` is sampled. A new overrun on the same edge as `ovr_clr` leaves the flag at 1.
- R10: With `mode_sel`=3 and `wake_en`=1, a character whose ninth bit is 0 is discarded without any effect: no load, no interrupt, no overrun. A character whose ninth bit is 1 is handled normally. `wake_en` has no effect in the other formats.
- R11: Bits keep shifting in while the holding register is full. If `rd_stb` arrives before the last bit, the new character is delivered normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One sampled bit is present this cycle |
| bit_val | input | 1 | Value of the sampled bit |
| mode_sel | input | 2 | Frame format: 0=7 bits, 1=8 bits, 2=8+parity, 3=9 bits |
| wake_en | input | 1 | Address-wake filter enable (format 3 only) |
| rd_stb | input | 1 | CPU read of the holding register |
| ovr_clr | input | 1 | Clears the overrun flag |
| hold_data | output | 8 | Holding register data |
| hold_extra | output | 1 | Parity or ninth data bit of the held character |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Each frame format is driven with bit patterns whose bits above the frame length differ from their lower bits. A truncated or over-long frame, or a misplaced extra bit, therefore shows up as a wrong value. One character is sent with idle cycles between its bits, which separates counting valid strobes from counting clock cycles.

The buffer-status scenarios are:
- a read in the middle of a character;
- a read on the final bit;
- no read at all, which separates a correct overrun policy from one that overwrites or that blocks too early.

A clear strobe that coincides with a new overrun tests the priority between them. In the wake-filter scenario, characters with the ninth bit at 0 and at 1 are sent both into an empty buffer and into a full one, and one more is sent in format 2, so that the filter is shown to act only in format 3 and never to cause an overrun.

// File: rtl/rxhold_pkg.sv
package rxhold_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    FRM_7  = 2'd0,
    FRM_8  = 2'd1,
    FRM_8P = 2'd2,
    FRM_9  = 2'd3
  } frame_e;

  // number of sampled bits in one character
  function automatic logic [CNT_W-1:0] frame_bits(frame_e m);
    case (m)
      FRM_7:   frame_bits = CNT_W'(DATA_W - 1);
      FRM_8:   frame_bits = CNT_W'(DATA_W);
      default: frame_bits = CNT_W'(WORD_W);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] place_bit(logic [WORD_W-1:0] w,
                                                  logic [CNT_W-1:0] idx,
                                                  logic b);
    logic [WORD_W-1:0] r;
    r = w;
    r[idx] = b;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] data_of(logic [WORD_W-1:0] w, frame_e m);
    if (m == FRM_7) return {1'b0, w[DATA_W-2:0]};
    return w[DATA_W-1:0];
  endfunction

  function automatic logic extra_of(logic [WORD_W-1:0] w, frame_e m);
    return (m == FRM_8P || m == FRM_9) ? w[DATA_W] : 1'b0;
  endfunction

  function automatic logic wake_drop(frame_e m, logic wake, logic extra);
    return (m == FRM_9) && wake && !extra;
  endfunction
endpackage

// File: rtl/rxhold_shift.sv
module rxhold_shift
  import rxhold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  frame_e            mode,
  output logic              char_done,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nx;
  logic [WORD_W-1:0] sh;

  assign cnt_nx    = cnt + 1'b1;
  assign word      = place_bit(sh, cnt, bit_val);
  assign char_done = bit_vld && (cnt_nx == frame_bits(mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_vld) begin
      if (char_done) begin
        cnt <= '0;
        sh  <= '0;
      end else begin
        cnt <= cnt_nx;
        sh  <= word;
      end
    end
  end
endmodule

// File: rtl/rxhold_buf.sv
module rxhold_buf
  import rxhold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [WORD_W-1:0] word,
  input  frame_e            mode,
  input  logic              wake_en,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_extra,
  output logic              rx_irq,
  output logic              ovr_flag,
  output logic              xfer,
  output logic              ovr_evt
);
  logic full;
  logic full_eff;
  logic accept;
  logic new_extra;

  assign new_extra = extra_of(word, mode);
  assign full_eff  = full && !rd_stb;
  assign accept    = char_done && !wake_drop(mode, wake_en, new_extra);
  assign xfer      = accept && !full_eff;
  assign ovr_evt   = accept && full_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_extra <= 1'b0;
      full       <= 1'b0;
      rx_irq     <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      rx_irq   <= xfer;
      full     <= xfer || full_eff;
      ovr_flag <= ovr_evt || (ovr_flag && !ovr_clr);
      if (xfer) begin
        hold_data  <= data_of(word, mode);
        hold_extra <= new_extra;
      end
    end
  end
endmodule

// File: rtl/rxhold_stage.sv
module rxhold_stage
  import rxhold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [1:0]        mode_sel,
  input  logic              wake_en,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_extra,
  output logic              rx_irq,
  output logic              ovr_flag
);
  frame_e            mode;
  logic              char_done;
  logic [WORD_W-1:0] word;
  logic              xfer;
  logic              ovr_evt;

  assign mode = frame_e'(mode_sel);

  rxhold_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .mode      (mode),
    .char_done (char_done),
    .word      (word)
  );

  rxhold_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (char_done),
    .word       (word),
    .mode       (mode),
    .wake_en    (wake_en),
    .rd_stb     (rd_stb),
    .ovr_clr    (ovr_clr),
    .hold_data  (hold_data),
    .hold_extra (hold_extra),
    .rx_irq     (rx_irq),
    .ovr_flag   (ovr_flag),
    .xfer       (xfer),
    .ovr_evt    (ovr_evt)
  );
endmodule

// File: rtl/rxhold_stage_chk.sv
module rxhold_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       wake_en,
  input logic       ovr_clr,
  input logic [7:0] hold_data,
  input logic       hold_extra,
  input logic       rx_irq,
  input logic       ovr_flag,
  input logic       xfer,
  input logic       ovr_evt
);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_irq_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> rx_irq);

  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(hold_data) && $stable(hold_extra) && !rx_irq && ovr_flag));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  assert_seven_bit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode_sel == 2'd0) |=> (!hold_data[7] && !hold_extra));

  assert_eight_no_extra_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode_sel == 2'd1) |=> !hold_extra);

  assert_wake_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode_sel == 2'd3 && wake_en) |=> hold_extra);
endmodule

bind rxhold_stage rxhold_stage_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .wake_en    (wake_en),
  .ovr_clr    (ovr_clr),
  .hold_data  (hold_data),
  .hold_extra (hold_extra),
  .rx_irq     (rx_irq),
  .ovr_flag   (ovr_flag),
  .xfer       (xfer),
  .ovr_evt    (ovr_evt)
);

// File: tb/rxhold_stage_test.sv
`timescale 1ns/1ps
module rxhold_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_val = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       wake_en = 1'b0;
  logic       rd_stb = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] hold_data;
  logic       hold_extra;
  logic       rx_irq;
  logic       ovr_flag;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rxhold_stage uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .mode_sel(mode_sel), .wake_en(wake_en), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .hold_data(hold_data), .hold_extra(hold_extra), .rx_irq(rx_irq), .ovr_flag(ovr_flag)
  );

  // behavioural reference: a queue of pending bits and plain flags
  bit         q[$];
  logic [7:0] m_data;
  logic       m_extra, m_irq, m_ovr, m_full;

  function automatic int bits_for(logic [1:0] m);
    return (m == 2'd0) ? 7 : (m == 2'd1) ? 8 : 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_data = 8'h00; m_extra = 1'b0; m_irq = 1'b0; m_ovr = 1'b0; m_full = 1'b0;
    end else begin
      logic [8:0] w;
      bit   got;
      bit   ovr_now;
      got = 1'b0; ovr_now = 1'b0; w = '0; m_irq = 1'b0;
      if (bit_vld) begin
        q.push_back(bit_val);
        if (q.size() == bits_for(mode_sel)) begin
          for (int i = 0; i < q.size(); i++) w[i] = q[i];
          q.delete();
          got = 1'b1;
        end
      end
      if (rd_stb) m_full = 1'b0;
      if (got && !(mode_sel == 2'd3 && wake_en && !w[8])) begin
        if (m_full) ovr_now = 1'b1;
        else begin
          m_data  = (mode_sel == 2'd0) ? {1'b0, w[6:0]} : w[7:0];
          m_extra = (mode_sel >= 2'd2) ? w[8] : 1'b0;
          m_full  = 1'b1;
          m_irq   = 1'b1;
        end
      end
      if (ovr_clr) m_ovr = 1'b0;
      if (ovr_now) m_ovr = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if ({hold_data, hold_extra, rx_irq, ovr_flag} !== {m_data, m_extra, m_irq, m_ovr}) begin
        misses++;
        $display("FAIL model R2-R11 cycle compare: actual data=%h extra=%b irq=%b ovr=%b expected data=%h extra=%b irq=%b ovr=%b",
                 hold_data, hold_extra, rx_irq, ovr_flag, m_data, m_extra, m_irq, m_ovr);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns at the falling edge right after the edge that sampled the last bit
  task automatic send_char(input logic [1:0] m, input logic [8:0] v,
                           input int rd_at, input int clr_at, input bit gap);
    int n;
    n = bits_for(m);
    mode_sel = m;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b1; bit_val = v[i];
      rd_stb = (i == rd_at); ovr_clr = (i == clr_at);
      if (gap && i < n - 1) begin
        @(negedge clk);
        bit_vld = 1'b0; rd_stb = 1'b0; ovr_clr = 1'b0;
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; rd_stb = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data", hold_data, 0);
    chk("R1 extra", hold_extra, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 ovr", ovr_flag, 0);

    send_char(2'd0, 9'h1D5, -1, -1, 1'b0);
    chk("R2 data", hold_data, 8'h55);
    chk("R2 extra", hold_extra, 0);
    chk("R6 irq on load", rx_irq, 1);
    @(negedge clk);
    chk("R6 irq single", rx_irq, 0);
    pulse_rd();

    send_char(2'd1, 9'h1A7, -1, -1, 1'b1);
    chk("R3 data gapped", hold_data, 8'hA7);
    chk("R3 extra", hold_extra, 0);
    pulse_rd();

    send_char(2'd2, 9'h13C, -1, -1, 1'b0);
    chk("R4 data", hold_data, 8'h3C);
    chk("R4 parity", hold_extra, 1);
    pulse_rd();

    send_char(2'd3, 9'h0C3, -1, -1, 1'b0);
    chk("R5 data", hold_data, 8'hC3);
    chk("R5 ninth", hold_extra, 0);

    send_char(2'd3, 9'h15A, 3, -1, 1'b0);
    chk("R11 data", hold_data, 8'h5A);
    chk("R11 ninth", hold_extra, 1);
    chk("R11 no overrun", ovr_flag, 0);

    send_char(2'd1, 9'h066, 7, -1, 1'b0);
    chk("R7 data", hold_data, 8'h66);
    chk("R7 irq", rx_irq, 1);
    chk("R7 no overrun", ovr_flag, 0);

    send_char(2'd1, 9'h199, -1, -1, 1'b0);
    chk("R8 data kept", hold_data, 8'h66);
    chk("R8 extra kept", hold_extra, 0);
    chk("R8 irq", rx_irq, 0);
    chk("R8 flag", ovr_flag, 1);
    repeat (5) @(negedge clk);
    chk("R9 sticky", ovr_flag, 1);
    pulse_rd();
    send_char(2'd1, 9'h033, -1, -1, 1'b0);
    chk("R9 load keeps flag data", hold_data, 8'h33);
    chk("R9 load keeps flag", ovr_flag, 1);
    pulse_clr();
    chk("R9 cleared", ovr_flag, 0);
    send_char(2'd1, 9'h044, -1, 7, 1'b0);
    chk("R9 set wins over clear", ovr_flag, 1);
    chk("R8 data kept again", hold_data, 8'h33);
    pulse_clr();
    pulse_rd();

    wake_en = 1'b1;
    send_char(2'd3, 9'h0AA, -1, -1, 1'b0);
    chk("R10 dropped data", hold_data, 8'h33);
    chk("R10 dropped irq", rx_irq, 0);
    send_char(2'd3, 9'h1BB, -1, -1, 1'b0);
    chk("R10 passed data", hold_data, 8'hBB);
    chk("R10 passed ninth", hold_extra, 1);
    chk("R10 passed irq", rx_irq, 1);
    send_char(2'd3, 9'h0EE, -1, -1, 1'b0);
    chk("R10 dropped while full no overrun", ovr_flag, 0);
    chk("R10 dropped while full data", hold_data, 8'hBB);
    pulse_rd();
    send_char(2'd2, 9'h07E, -1, -1, 1'b0);
    chk("R10 other format data", hold_data, 8'h7E);
    chk("R10 other format irq", rx_irq, 1);
    wake_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule